// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus (I2C-compatible). Behind it sits a 256-byte memory with byte addressing. A fast system clock samples the SCL and SDA lines. The block detects start, repeated-start and stop conditions, and it pulls SDA low through a single open-drain enable output. A bus master addresses the block with a 7-bit device address. The upper four bits of that address are fixed at `1010`, and the low three bits must equal the strap inputs.

A write transaction carries a word address and then any number of data bytes. The bytes are staged in a 16-entry page buffer. They reach the memory only after the closing stop condition, during a self-timed write cycle whose length in system clocks is a parameter. The block does not answer its device address while that cycle runs. When the write-protect input is high, the upper half of the memory is guarded.

Reads use one shared address counter. This counter serves current-address reads, random reads (a write header followed by a repeated start) and sequential reads, which run past the last location and continue at address 0.

Top module: `ee_i2c_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins a header byte in any state, including a repeated start in the middle of a transaction. A stop condition (SDA rising while SCL is high) ends the transaction and releases SDA.
- R2: The block acknowledges a header byte only when its upper seven bits equal `1010` followed by `strap_i[2:0]`. Bit 0 of the header selects the direction: 1 is read, 0 is write. Any other header receives no acknowledge.
- R3: In a write, every word-address byte and every data byte is acknowledged. Data bytes are stored at consecutive addresses and become readable after the write cycle that the stop starts.
- R4: Within one write transaction only the low four address bits advance. A transaction with more than 16 data bytes wraps inside its 16-byte page, and the later bytes overwrite the earlier ones.
- R5: A random read (write header, word address, repeated start, read header) returns the byte stored at the word address just sent.
- R6: A read header that has no word address before it returns the byte at the last accessed address plus one.
- R7: While the master acknowledges, a read sends the bytes of consecutive addresses. After address 255 it continues with address 0.
- R8: When the master does not acknowledge a read byte, the block releases SDA and drives nothing on the following clock.
- R9: When `wp_i` is high, data bytes aimed at addresses 128 to 255 are still acknowledged but leave the memory unchanged. Addresses 0 to 127 are written normally. When `wp_i` is low, all addresses are written.
- R10: From the stop that ends a write with data until the write cycle completes, the block does not acknowledge its own device address and keeps SDA released. After the cycle it answers again.
- R11: After reset, SDA is released (`sda_oe_o` = 0).
- R12: `sda_oe_o` changes only while SCL is low, or at a start or stop condition. SDA therefore stays stable during every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| strap_i | input | 3 | Low three device-address bits |
| wp_i | input | 1 | Write protect for the upper half of the array |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
A corrupted address counter does not show up at once. It shows only at the next read, which returns a byte from the wrong location, or at the next write, which commits to the wrong place. The bench therefore pairs every write with a read-back, and it also checks the current-address read that follows a random read and the wrap at 255. A wrong protocol state shows within one byte: an acknowledge is missing or comes in the wrong place, or SDA moves while SCL is high, and the bench samples that twice in every high phase. A write-cycle flag that stays set too long, or clears too early, shows at the next header, which is acknowledged or ignored wrongly.

// File: rtl/ee_i2c_pkg.sv
package ee_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WORD, ST_DATA, ST_ACK, ST_TX, ST_MACK, ST_TXW
  } ee_state_t;
endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ee_array.sv
module ee_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ee_wr_seq.sv
module ee_wr_seq #(
  parameter int CYCLES = 64,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  output logic             busy,
  output logic             commit,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  localparam int CW   = $clog2(CYCLES + 1);
  localparam int PAGE = 2 ** IDX_W;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (go && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == CW'(CYCLES - 1)) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assign commit = busy && (cnt < CW'(PAGE));
  assign idx    = cnt[IDX_W-1:0];
  assign done   = busy && (cnt == CW'(CYCLES - 1));
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave
  import ee_i2c_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 4,
  parameter int         WR_CYCLES   = 64,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'b1010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int PAGE = 2 ** PAGE_W;
  localparam int HI_W = ADDR_W - PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  ee_state_t state, ack_nxt;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [6:0] tx;
  logic [ADDR_W-1:0] ptr;
  logic [HI_W-1:0] pg;
  logic [7:0] pbuf [PAGE];
  logic [PAGE-1:0] vld;
  logic [7:0] rdata;
  logic busy, commit, done;
  logic [PAGE_W-1:0] idx;
  logic mem_we, dev_hit, byte_end, buf_we, load_tx;
  logic [ADDR_W-1:0] mem_waddr;

  ee_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ee_wr_seq #(.CYCLES(WR_CYCLES), .IDX_W(PAGE_W)) u_wseq (
    .clk(clk), .rst(rst), .go(stop_det && (|vld)),
    .busy(busy), .commit(commit), .idx(idx), .done(done)
  );

  assign mem_we    = commit && vld[idx] && !(wp_i && pg[HI_W-1]);
  assign mem_waddr = {pg, idx};

  ee_array #(.AW(ADDR_W), .DW(8)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(pbuf[idx]),
    .raddr(ptr), .rdata(rdata)
  );

  assign dev_hit  = (sh[7:1] == {DEV_ID, strap_i}) && !busy;
  assign byte_end = scl_fall && (cnt == 4'd8) && !start_det && !stop_det;
  assign buf_we   = byte_end && (state == ST_DATA);
  assign load_tx  = scl_fall && !start_det && !stop_det &&
                    (((state == ST_ACK) && (ack_nxt == ST_TX)) || (state == ST_TXW));

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[ptr[PAGE_W-1:0]] <= sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ack_nxt  <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      ptr      <= '0;
      pg       <= '0;
      vld      <= '0;
      sda_oe_o <= 1'b0;
    end else begin
      if (done) vld <= '0;
      if (start_det) begin
        state    <= ST_DEV;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
        if (!busy) pg <= ptr[ADDR_W-1:PAGE_W];
      end else begin
        case (state)
          ST_DEV, ST_WORD, ST_DATA: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (byte_end) begin
              cnt <= '0;
              if (state == ST_DEV) begin
                if (dev_hit) begin
                  sda_oe_o <= 1'b1;
                  state    <= ST_ACK;
                  ack_nxt  <= sh[0] ? ST_TX : ST_WORD;
                  if (!sh[0]) vld <= '0;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe_o <= 1'b1;
                state    <= ST_ACK;
                ack_nxt  <= ST_DATA;
                if (state == ST_WORD) begin
                  ptr <= sh[ADDR_W-1:0];
                end else begin
                  vld[ptr[PAGE_W-1:0]] <= 1'b1;
                  ptr[PAGE_W-1:0]      <= ptr[PAGE_W-1:0] + 1'b1;
                end
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            sda_oe_o <= 1'b0;
            state    <= ack_nxt;
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe_o <= 1'b0;
                state    <= ST_MACK;
              end else begin
                tx       <= {tx[5:0], 1'b0};
                sda_oe_o <= ~tx[6];
              end
            end
          end
          ST_MACK: if (scl_rise) state <= sda_s ? ST_IDLE : ST_TXW;
          default: ;
        endcase
        if (load_tx) begin
          tx       <= rdata[6:0];
          sda_oe_o <= ~rdata[7];
          cnt      <= '0;
          ptr      <= ptr + 1'b1;
          state    <= ST_TX;
        end
      end
    end
  end
endmodule

// File: rtl/ee_i2c_chk.sv
module ee_i2c_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic              wp_i,
  input logic              sda_oe_o
);
  // R10
  quiet_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe_o);

  // R10
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det));

  // R12
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe_o != $past(sda_oe_o)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

  // R9
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_waddr[ADDR_W-1]) |-> !wp_i);

  // R3
  commit_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
endmodule

bind ee_i2c_slave ee_i2c_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det),
  .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr), .wp_i(wp_i), .sda_oe_o(sda_oe_o)
);

// File: tb/ee_i2c_slave_tb.sv
module ee_i2c_slave_tb;
  localparam int WR = 400;
  localparam int Q  = 5;
  localparam int H  = 10;
  localparam logic [2:0] STRAP = 3'b101;
  // {wp, addr, data, expected read-back}
  localparam logic [24:0] VEC [0:7] = '{
    {1'b0, 8'h05, 8'h3C, 8'h3C},
    {1'b0, 8'h80, 8'hA5, 8'hA5},
    {1'b0, 8'hFF, 8'h11, 8'h11},
    {1'b1, 8'h80, 8'h77, 8'hA5},
    {1'b1, 8'h7F, 8'h42, 8'h42},
    {1'b1, 8'hFF, 8'h99, 8'h11},
    {1'b0, 8'h00, 8'hE1, 8'hE1},
    {1'b0, 8'hFF, 8'h5A, 8'h5A}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic sda_oe;
  wire  line = m_sda & ~sda_oe;
  int total = 0, bad = 0;
  logic [7:0] rbuf [0:31];
  bit ack;

  always #4 clk = ~clk;

  ee_i2c_slave #(.WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(line),
    .strap_i(STRAP), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; ticks(Q); m_scl = 1'b1; ticks(H);
    m_sda = 1'b0; ticks(H); m_scl = 1'b0; ticks(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; ticks(Q); m_scl = 1'b1; ticks(H);
    m_sda = 1'b1; ticks(H);
  endtask

  task automatic put_bit(input bit b);
    m_sda = b; ticks(Q); m_scl = 1'b1; ticks(H); m_scl = 1'b0; ticks(Q);
  endtask

  task automatic get_bit(output bit b);
    bit b1, b2;
    m_sda = 1'b1; ticks(Q); m_scl = 1'b1; ticks(4);
    b1 = line; ticks(H - 4); b2 = line;
    m_scl = 1'b0; ticks(Q);
    chk("R12 sda stable in high phase", b2, b1);
    b = b1;
  endtask

  task automatic send_byte(input logic [7:0] v, output bit a);
    bit r;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(r);
    a = !r;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] v);
    bit r;
    for (int i = 7; i >= 0; i--) begin get_bit(r); v[i] = r; end
    put_bit(!mack);
  endtask

  task automatic wr_seq(input logic [7:0] addr, input int n, input logic [7:0] d0,
                        input string req, input bit wait_done);
    bit a;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a); chk({req, " write header ack"}, a, 1);
    send_byte(addr, a);                   chk({req, " word address ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d0 + 8'(i), a);           chk({req, " data ack"}, a, 1);
    end
    bus_stop();
    if (wait_done) ticks(WR + 20);
  endtask

  task automatic rd_tail(input int n);
    bit r;
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
    get_bit(r);
    chk("R8 sda released after master nack", r, 1);
    bus_stop();
  endtask

  task automatic rd_random(input logic [7:0] addr, input int n);
    bit a;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a); chk("R1 header ack", a, 1);
    send_byte(addr, a);                   chk("R5 word address ack", a, 1);
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, a); chk("R1 repeated start read ack", a, 1);
    rd_tail(n);
  endtask

  task automatic rd_current(input int n);
    bit a;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, a); chk("R6 read header ack", a, 1);
    rd_tail(n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ticks(5);
    rst = 1'b0;
    ticks(5);
    chk("R11 reset releases sda", sda_oe, 0);

    // table: byte write then random read-back (R3, R5, R9)
    for (int v = 0; v < 8; v++) begin
      wp = VEC[v][24];
      wr_seq(VEC[v][23:16], 1, VEC[v][15:8], "R9", 1'b1);
      rd_random(VEC[v][23:16], 1);
      chk("R5 R9 read-back", rbuf[0], VEC[v][7:0]);
    end
    wp = 1'b0;

    // R6: last access was a read of 0xFF, so the counter is at 0x00
    rd_current(1);
    chk("R6 current address read", rbuf[0], 8'hE1);

    // R7: sequential read across the end of the array
    wr_seq(8'hFE, 1, 8'h6B, "R7", 1'b1);
    rd_random(8'hFE, 3);
    chk("R7 seq byte 0", rbuf[0], 8'h6B);
    chk("R7 seq byte 1", rbuf[1], 8'h5A);
    chk("R7 seq wrap to 0", rbuf[2], 8'hE1);

    // R3: full 16-byte page write
    wr_seq(8'h20, 16, 8'h30, "R3", 1'b1);
    rd_random(8'h20, 16);
    for (int i = 0; i < 16; i++) chk("R3 page byte", rbuf[i], 8'h30 + i);

    // R4: 18 bytes from 0x4E wrap inside page 0x40
    wr_seq(8'h4E, 18, 8'h90, "R4", 1'b1);
    rd_random(8'h4E, 2);
    chk("R4 wrap overwrite 0x4E", rbuf[0], 8'hA0);
    chk("R4 wrap overwrite 0x4F", rbuf[1], 8'hA1);
    rd_random(8'h40, 1);
    chk("R4 wrap start of page", rbuf[0], 8'h92);
    rd_random(8'h2F, 2);
    chk("R4 neighbour page untouched", rbuf[0], 8'h3F);

    // R2: address mismatches
    bus_start();
    send_byte({4'b1010, 3'b100, 1'b0}, ack);
    chk("R2 strap mismatch nack", ack, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b0}, ack);
    chk("R2 fixed nibble mismatch nack", ack, 0);
    bus_stop();

    // R10: silent during write cycle, answers afterwards
    wr_seq(8'h10, 1, 8'hC4, "R10", 1'b0);
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    chk("R10 no ack during write cycle", ack, 0);
    bus_stop();
    ticks(WR + 20);
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    chk("R10 ack after write cycle", ack, 1);
    bus_stop();
    rd_random(8'h10, 1);
    chk("R10 write completed", rbuf[0], 8'hC4);
    chk("R1 sda released after stop", sda_oe, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule